// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block decides which of four DMA channels a transfer controller serves next. Each channel has a request line and a mask bit. A command word sets three things: whether requests are active-high or active-low, whether priority is fixed or rotating, and whether the whole controller is switched off. While the surrounding controller reports that it is idle, the arbiter conditions the requests on every clock edge. If an unmasked request remains, it raises a hold request toward the bus owner and latches the winning channel's index.

The winner is also kept as the last-served channel. Rotating priority uses this record so that the channel served most recently falls to the bottom of the order. While the controller is busy, the outputs stay frozen. The sequencing logic can therefore use the granted index for the whole service period.

Top module: `dma_req_arbiter`

## Requirements
- R1: After a synchronous reset, hold_o is 0, grant_o is 0 and last_o is 3, so rotating priority first favours channel 0.
- R2: When command bit 2 is 1 and idle_i is 1, no arbitration takes place. On the next edge hold_o becomes 0, and grant_o and last_o keep their values.
- R3: When command bit 6 is 1, a request bit of 0 means the channel is requesting. When bit 6 is 0, a request bit of 1 means requesting.
- R4: A channel whose mask bit is 1 is removed from the pending set before the priority decision, so it can never win.
- R5: When command bit 4 is 0, priority is fixed and the lowest-numbered pending channel wins (channel 0 highest, channel 3 lowest).
- R6: When command bit 4 is 1, the search starts at channel (last_o + 1) mod 4 and walks upward with wrap-around. The channel in last_o is therefore the lowest priority.
- R7: When idle_i is 1, the controller is enabled and any unmasked request is pending, then on the next edge hold_o is 1 and both grant_o and last_o equal the winning channel.
- R8: When idle_i is 1, the controller is enabled and no unmasked request is pending, then on the next edge hold_o is 0, and grant_o and last_o are unchanged.
- R9: While idle_i is 0, hold_o, grant_o and last_o keep their values, whatever the requests, mask and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Raw per-channel request lines |
| mask_i | input | 4 | Per-channel mask, 1 removes the channel |
| cmd_i | input | 8 | Command word: bit 2 disable, bit 4 rotate, bit 6 active-low requests |
| idle_i | input | 1 | Controller idle; arbitration allowed only when 1 |
| hold_o | output | 1 | Registered hold request to the bus owner |
| grant_o | output | 2 | Registered index of the winning channel |
| last_o | output | 2 | Registered index of the last-served channel |

## Verification
Several rules are checked by assertions on every clock cycle:
- The outputs stay frozen while the controller is busy.
- A disabled or empty idle cycle drops the hold.
- Each grant goes to a channel that was really pending and leaves grant and last-served equal.
- Under fixed priority, no lower-numbered channel was pending when a grant was made.

The assertions cannot show that the polarity inversion, masking and rotating wrap order give the right winner across all combinations. A bench sweep covers these. It runs every request, mask and command pattern against an arithmetic model of the search order, carried across a changing last-served history.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Command word layout decoded by this arbiter
  localparam int CMD_W           = 8;
  localparam int CMD_DISABLE_BIT = 2;
  localparam int CMD_ROTATE_BIT  = 4;
  localparam int CMD_ACT_LOW_BIT = 6;
endpackage

// File: rtl/dma_req_cond.sv
module dma_req_cond #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic         act_low_i,
  output logic [N-1:0] pend_o
);
  // Per-channel polarity correction then masking
  for (genvar ch = 0; ch < N; ch++) begin : g_ch
    logic active;
    assign active     = act_low_i ? ~req_i[ch] : req_i[ch];
    assign pend_o[ch] = active & ~mask_i[ch];
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic          rotate_i,
  input  logic [IW-1:0] last_i,
  output logic          valid_o,
  output logic [IW-1:0] win_o
);
  localparam logic [IW-1:0] LAST_CH = IW'(N - 1);

  logic [IW-1:0] start;

  // First channel searched: 0 for fixed order, one past last for rotating
  always_comb begin
    if (!rotate_i)             start = '0;
    else if (last_i == LAST_CH) start = '0;
    else                        start = last_i + 1'b1;
  end

  // Walk the order from its far end so the nearest pending channel wins
  always_comb begin
    win_o   = '0;
    valid_o = |pend_i;
    for (int k = N - 1; k >= 0; k--) begin
      int s;
      s = int'(start) + k;
      if (s >= N) s = s - N;
      if (pend_i[s]) win_o = IW'(s);
    end
  end
endmodule

// File: rtl/dma_arb_regs.sv
module dma_arb_regs #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle_i,
  input  logic          disable_i,
  input  logic          valid_i,
  input  logic [IW-1:0] win_i,
  output logic          hold_o,
  output logic [IW-1:0] grant_o,
  output logic [IW-1:0] last_o
);
  localparam logic [IW-1:0] LAST_RST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o  <= 1'b0;
      grant_o <= '0;
      last_o  <= LAST_RST;
    end else if (idle_i) begin
      if (disable_i || !valid_i) begin
        hold_o <= 1'b0;
      end else begin
        hold_o  <= 1'b1;
        grant_o <= win_i;
        last_o  <= win_i;
      end
    end
  end

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !idle_i |=> ($stable(hold_o) && $stable(grant_o) && $stable(last_o)));

  // R2
  disabled_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_i && disable_i) |=> (!hold_o && $stable(grant_o) && $stable(last_o)));

  // R8
  empty_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !disable_i && !valid_i) |=> (!hold_o && $stable(last_o)));

  // R7
  grant_records_last_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !disable_i && valid_i) |=> (hold_o && grant_o == last_o));
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     mask_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             idle_i,
  output logic             hold_o,
  output logic [IW-1:0]    grant_o,
  output logic [IW-1:0]    last_o
);
  logic [N-1:0]  pend_w;
  logic          valid_w;
  logic [IW-1:0] win_w;
  logic          unused_cmd_bits;

  assign unused_cmd_bits = ^cmd_i;

  dma_req_cond #(.N(N)) u_cond (
    .req_i     (req_i),
    .mask_i    (mask_i),
    .act_low_i (cmd_i[CMD_ACT_LOW_BIT]),
    .pend_o    (pend_w)
  );

  dma_prio_pick #(.N(N), .IW(IW)) u_pick (
    .pend_i   (pend_w),
    .rotate_i (cmd_i[CMD_ROTATE_BIT]),
    .last_i   (last_o),
    .valid_o  (valid_w),
    .win_o    (win_w)
  );

  dma_arb_regs #(.N(N), .IW(IW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .idle_i    (idle_i),
    .disable_i (cmd_i[CMD_DISABLE_BIT]),
    .valid_i   (valid_w),
    .win_i     (win_w),
    .hold_o    (hold_o),
    .grant_o   (grant_o),
    .last_o    (last_o)
  );

  // R7
  winner_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !cmd_i[CMD_DISABLE_BIT] && valid_w) |=> (($past(pend_w) >> grant_o) & N'(1)) != '0);

  // R5
  fixed_lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !cmd_i[CMD_DISABLE_BIT] && !cmd_i[CMD_ROTATE_BIT] && valid_w)
      |=> (($past(pend_w) & ~({N{1'b1}} << grant_o)) == '0));
endmodule

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
  localparam int PERIOD = 10;
  localparam int N      = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] req, mask;
  logic [7:0] cmd;
  logic       idle;
  logic       hold;
  logic [1:0] grant, last;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic       m_hold;
  int         m_grant, m_last;

  always #(PERIOD/2) clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .cmd_i(cmd),
    .idle_i(idle), .hold_o(hold), .grant_o(grant), .last_o(last)
  );

  function automatic int pick(logic [3:0] p, logic rot, int lst);
    int start = rot ? (lst + 1) % N : 0;
    for (int k = 0; k < N; k++) begin
      if (p[(start + k) % N]) return (start + k) % N;
    end
    return 0;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (hold !== m_hold || int'(grant) != m_grant || int'(last) != m_last) begin
      errors++;
      $display("FAIL %s: hold=%0b grant=%0d last=%0d expected hold=%0b grant=%0d last=%0d",
               tag, hold, grant, last, m_hold, m_grant, m_last);
    end
  endtask

  // Drive at negedge, update model, check a quarter period after the edge
  task automatic apply(logic [3:0] r, logic [3:0] m, logic [7:0] c, logic idl);
    logic [3:0] act, eff;
    string tag;
    req = r; mask = m; cmd = c; idle = idl;
    act = c[6] ? ~r : r;
    eff = act & ~m;
    if (!idl) tag = "R9";
    else if (c[2]) tag = "R2";
    else if (eff == 0) tag = (act != 0) ? "R8 R4" : "R8";
    else begin
      tag = c[4] ? "R7 R6" : "R7 R5";
      if (c[6]) tag = {tag, " R3"};
      if (m != 0) tag = {tag, " R4"};
    end
    if (idl) begin
      if (c[2] || eff == 0) m_hold = 1'b0;
      else begin
        m_hold  = 1'b1;
        m_grant = pick(eff, c[4], m_last);
        m_last  = m_grant;
      end
    end
    @(posedge clk);
    #(PERIOD/4);
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; req = '0; mask = '0; cmd = '0; idle = 1'b0;
    m_hold = 1'b0; m_grant = 0; m_last = 3;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    compare("R1");
    @(negedge clk);
    rst = 1'b0;
    // R6: after reset rotating order starts at channel 0
    apply(4'b1111, 4'b0000, 8'h10, 1'b1);
    // R6: last=0 so channel 1 beats channel 0
    apply(4'b0011, 4'b0000, 8'h10, 1'b1);
    // R3: active-low, only channel 0 line low
    apply(4'b1110, 4'b0000, 8'h40, 1'b1);
    // R4: everything requested, only channel 2 unmasked
    apply(4'b1111, 4'b1011, 8'h00, 1'b1);
    // R9: busy cycle ignores a new winner
    apply(4'b0001, 4'b0000, 8'h00, 1'b0);
    // R2: disabled drops hold
    apply(4'b0001, 4'b0000, 8'h04, 1'b1);
    // Sweep every command combination, request and mask
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 16; r++) begin
        for (int m = 0; m < 16; m++) begin
          logic [7:0] cw;
          cw = {1'b0, c[2], 1'b0, c[1], 1'b0, c[0], 2'b00};
          apply(4'(r), 4'(m), cw, ((r + m + c) % 5) != 0);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule